// File: doc/BRIEF.md
# Maskable Interrupt Controller with Halt Wake

This block gathers thirty-two single-cycle event pulses from peripherals into a pending flag register and decides, against a per-source enable mask and a global enable word, when to interrupt the processor. Software programs the controller through a small 16-bit register port. The 32-bit enable mask and the 32-bit pending flags are each reached as two 16-bit halves. Pending flags are acknowledged by writing ones to them.

There are two outputs. The interrupt request is registered. It is high whenever the global enable word is nonzero and at least one enabled source is pending. It is evaluated from the state that results at each clock edge, so a register write that enables a request shows on the output at the same edge that stores the write. A separate wake pulse releases a halted processor whenever an enabled source fires. The wake pulse ignores the global enable, so a core with interrupts globally off can still leave its halt.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset, every mapped register reads 0, and irqOut and wakeOut are 0.
- R2: Register addresses are: 0 for the global enable word, 1 for enable mask bits 15..0, 2 for enable mask bits 31..16, 3 for pending bits 15..0 and 4 for pending bits 31..16. Source n sits at bit n mod 16 of its half. A write to one half leaves the other half unchanged, and every mapped register reads back through rdData.
- R3: A high srcPulse[n] at a clock edge sets pending bit n. A pending bit never becomes set without its pulse.
- R4: A write to address 3 or 4 clears each pending bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged.
- R5: When a pulse on source n and a clear of pending bit n land at the same edge, bit n ends up set.
- R6: After every clock edge, irqOut equals (global enable word != 0) AND (enable mask & pending != 0), computed from the register values stored at that edge.
- R7: Writing a nonzero global enable word while an enabled bit is pending raises irqOut at the edge of the write. Any nonzero value counts, including values with bit 0 clear. Writing 0 drops irqOut.
- R8: With the global enable word nonzero, writing the enable mask so that a bit that is already pending becomes enabled raises irqOut at the edge of the write.
- R9: wakeOut is high for the cycle after each edge at which some srcPulse[n] is high and enable bit n is set, whatever the global enable word holds. It is low after every other edge.
- R10: Writes to addresses 5 to 7 change no register, and reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Write strobe for the register port |
| regAddr | input | 3 | Register address |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr, combinational |
| srcPulse | input | 32 | Event pulses, one bit per source |
| irqOut | output | 1 | Registered interrupt request to the processor |
| wakeOut | output | 1 | Registered one-cycle wake-from-halt pulse |

## Verification
Two cases can fall in the same cycle. The first is a source pulse and a software acknowledge of the same pending bit. The bench drives both at one edge, then reads the pending half back and expects the bit to be set, while a neighbouring bit cleared by the same write must be 0. The second is a register write and a change in the interrupt request. The bench writes the global enable word or the enable mask and samples irqOut in the half cycle after that edge, expecting it to have moved already. Wake is judged against a global enable of zero, so that a wake pulse together with a quiet irqOut shows the two paths apart.

// File: rtl/intc_pkg.sv
package intc_pkg;
  parameter int unsigned SRC_COUNT = 32;
  parameter int unsigned HALF_W    = 16;
  localparam int unsigned NUM_HALF = SRC_COUNT / HALF_W;
  localparam int unsigned NUM_REGS = 1 + 2 * NUM_HALF;
  localparam int unsigned ADDR_W   = $clog2(NUM_REGS + 1);

  // Write strobes from control to datapath
  typedef struct packed {
    logic                wrMaster;
    logic [NUM_HALF-1:0] wrEn;
    logic [NUM_HALF-1:0] clrPend;
    logic [HALF_W-1:0]   data;
  } strobe_t;
endpackage

// File: rtl/irq_wake_dp.sv
module irq_wake_dp
  import intc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic [SRC_COUNT-1:0] srcPulse,
  output logic [HALF_W-1:0]    masterQ,
  output logic [HALF_W-1:0]    masterNext,
  output logic [SRC_COUNT-1:0] enQ,
  output logic [SRC_COUNT-1:0] enNext,
  output logic [SRC_COUNT-1:0] pendQ,
  output logic [SRC_COUNT-1:0] pendNext,
  output logic [HALF_W-1:0]    rdData
);
  assign masterNext = strb.wrMaster ? strb.data : masterQ;

  always_ff @(posedge clk) begin
    if (!rstN) masterQ <= '0;
    else       masterQ <= masterNext;
  end

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    logic [HALF_W-1:0] clrMask;
    assign clrMask = strb.clrPend[h] ? strb.data : '0;
    assign enNext[h*HALF_W +: HALF_W] = strb.wrEn[h] ? strb.data : enQ[h*HALF_W +: HALF_W];
    // A raise in the same cycle as a clear wins
    assign pendNext[h*HALF_W +: HALF_W] =
      (pendQ[h*HALF_W +: HALF_W] & ~clrMask) | srcPulse[h*HALF_W +: HALF_W];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enQ[h*HALF_W +: HALF_W]   <= '0;
        pendQ[h*HALF_W +: HALF_W] <= '0;
      end else begin
        enQ[h*HALF_W +: HALF_W]   <= enNext[h*HALF_W +: HALF_W];
        pendQ[h*HALF_W +: HALF_W] <= pendNext[h*HALF_W +: HALF_W];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == '0) rdData = masterQ;
    for (int h = 0; h < NUM_HALF; h++) begin
      if (rdAddr == ADDR_W'(1 + h))            rdData = enQ[h*HALF_W +: HALF_W];
      if (rdAddr == ADDR_W'(1 + NUM_HALF + h)) rdData = pendQ[h*HALF_W +: HALF_W];
    end
  end
endmodule

// File: rtl/irq_wake_fsm.sv
module irq_wake_fsm
  import intc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWr,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [HALF_W-1:0]    regWrData,
  input  logic [SRC_COUNT-1:0] srcPulse,
  input  logic [HALF_W-1:0]    masterNext,
  input  logic [SRC_COUNT-1:0] enQ,
  input  logic [SRC_COUNT-1:0] enNext,
  input  logic [SRC_COUNT-1:0] pendNext,
  output strobe_t              strb,
  output logic                 irqQ,
  output logic                 wakeQ
);
  logic [NUM_HALF-1:0] wrEnVec;
  logic [NUM_HALF-1:0] clrVec;

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_dec
    assign wrEnVec[h] = regWr && (regAddr == ADDR_W'(1 + h));
    assign clrVec[h]  = regWr && (regAddr == ADDR_W'(1 + NUM_HALF + h));
  end

  always_comb begin
    strb.wrMaster = regWr && (regAddr == '0);
    strb.wrEn     = wrEnVec;
    strb.clrPend  = clrVec;
    strb.data     = regWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqQ  <= 1'b0;
      wakeQ <= 1'b0;
    end else begin
      irqQ  <= (|masterNext) && (|(enNext & pendNext));
      wakeQ <= |(srcPulse & enQ);
    end
  end
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
  import intc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWr,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [HALF_W-1:0]    regWrData,
  output logic [HALF_W-1:0]    regRdData,
  input  logic [SRC_COUNT-1:0] srcPulse,
  output logic                 irqOut,
  output logic                 wakeOut
);
  strobe_t              strb;
  logic [HALF_W-1:0]    masterQ, masterNext;
  logic [SRC_COUNT-1:0] enQ, enNext, pendQ, pendNext;

  irq_wake_fsm u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .srcPulse(srcPulse), .masterNext(masterNext),
    .enQ(enQ), .enNext(enNext), .pendNext(pendNext),
    .strb(strb), .irqQ(irqOut), .wakeQ(wakeOut)
  );

  irq_wake_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdAddr(regAddr), .srcPulse(srcPulse),
    .masterQ(masterQ), .masterNext(masterNext), .enQ(enQ), .enNext(enNext),
    .pendQ(pendQ), .pendNext(pendNext), .rdData(regRdData)
  );
endmodule

// File: rtl/irq_wake_chk.sv
module irq_wake_chk
  import intc_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [SRC_COUNT-1:0] srcPulse,
  input logic [HALF_W-1:0]    masterQ,
  input logic [SRC_COUNT-1:0] enQ,
  input logic [SRC_COUNT-1:0] pendQ,
  input logic                 irqOut,
  input logic                 wakeOut
);
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    ##1 (irqOut == ((|masterQ) && (|(enQ & pendQ))))); // R6

  AST_WAKE_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    (|(srcPulse & enQ)) |=> wakeOut); // R9

  AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(|(srcPulse & enQ)) |=> !wakeOut); // R9

  AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (|srcPulse) |=> ((pendQ & $past(srcPulse)) == $past(srcPulse))); // R5

  AST_NO_SPURIOUS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & ~$past(pendQ) & ~$past(srcPulse)) == '0)); // R3
endmodule

bind irq_wake_ctrl irq_wake_chk u_chk (
  .clk(clk), .rstN(rstN), .srcPulse(srcPulse), .masterQ(masterQ),
  .enQ(enQ), .pendQ(pendQ), .irqOut(irqOut), .wakeOut(wakeOut)
);

// File: tb/irq_wake_ctrl_tb.sv
`timescale 1ns/1ps
module irq_wake_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [31:0] srcPulse = '0;
  logic        irqOut, wakeOut;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  irq_wake_ctrl u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .srcPulse(srcPulse),
    .irqOut(irqOut), .wakeOut(wakeOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [31:0] p = '0);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d; srcPulse = p;
    @(negedge clk);
    regWr = 1'b0; srcPulse = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic pulse(input logic [31:0] p);
    @(negedge clk);
    srcPulse = p;
    @(negedge clk);
    srcPulse = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      check("R1 reg after reset", 32'(d), 32'h0);
    end
    check("R1 irqOut after reset", 32'(irqOut), 32'h0);
    check("R1 wakeOut after reset", 32'(wakeOut), 32'h0);
  endtask

  task automatic t_enable_halves();
    logic [15:0] d;
    wr(3'd1, 16'hA5A5);
    wr(3'd2, 16'h0F0F);
    rd(3'd1, d); check("R2 enable low", 32'(d), 32'hA5A5);
    rd(3'd2, d); check("R2 enable high", 32'(d), 32'h0F0F);
    wr(3'd1, 16'h0001);
    rd(3'd2, d); check("R2 high kept on low write", 32'(d), 32'h0F0F);
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0000);
  endtask

  task automatic t_raise();
    logic [15:0] d;
    pulse(32'h8002_0001);
    rd(3'd3, d); check("R3 pending low", 32'(d), 32'h0001);
    rd(3'd4, d); check("R3 pending high", 32'(d), 32'h8002);
  endtask

  task automatic t_clear();
    logic [15:0] d;
    wr(3'd4, 16'h0002);
    rd(3'd4, d); check("R4 clear one high bit", 32'(d), 32'h8000);
    rd(3'd3, d); check("R4 low untouched", 32'(d), 32'h0001);
    wr(3'd3, 16'h0000);
    rd(3'd3, d); check("R4 zero write keeps", 32'(d), 32'h0001);
    wr(3'd3, 16'hFFFF);
    wr(3'd4, 16'hFFFF);
    rd(3'd3, d); check("R4 cleared low", 32'(d), 32'h0);
  endtask

  task automatic t_race();
    logic [15:0] d;
    pulse(32'h0000_0040);
    wr(3'd3, 16'h0060, 32'h0000_0020);
    rd(3'd3, d); check("R5 raise beats clear", 32'(d), 32'h0020);
    wr(3'd3, 16'hFFFF);
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    wr(3'd1, 16'h1234);
    for (int a = 5; a < 8; a++) wr(3'(a), 16'hFFFF);
    rd(3'd0, d); check("R10 master unchanged", 32'(d), 32'h0);
    rd(3'd1, d); check("R10 enable unchanged", 32'(d), 32'h1234);
    rd(3'd3, d); check("R10 pending unchanged", 32'(d), 32'h0);
    rd(3'd6, d); check("R10 unmapped read", 32'(d), 32'h0);
    wr(3'd1, 16'h0000);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    pulse(32'h0000_0008);
    check("R6 no master no enable", 32'(irqOut), 32'h0);
    wr(3'd0, 16'h0001);
    check("R6 master but not enabled", 32'(irqOut), 32'h0);
    wr(3'd1, 16'h0008);
    check("R8 enabling pending bit", 32'(irqOut), 32'h1);
    wr(3'd0, 16'h0000);
    check("R7 master zero drops irq", 32'(irqOut), 32'h0);
    wr(3'd0, 16'h0100);
    check("R7 nonzero master raises irq", 32'(irqOut), 32'h1);
    rd(3'd0, d); check("R7 master read back", 32'(d), 32'h0100);
    wr(3'd3, 16'h0008);
    check("R6 ack drops irq", 32'(irqOut), 32'h0);
    pulse(32'h0001_0000);
    check("R6 disabled source no irq", 32'(irqOut), 32'h0);
    wr(3'd2, 16'h0001);
    check("R8 enabling high half bit", 32'(irqOut), 32'h1);
    wr(3'd4, 16'h0001);
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0000);
  endtask

  task automatic t_wake();
    wr(3'd1, 16'h0010);
    @(negedge clk);
    srcPulse = 32'h0000_0010;
    @(negedge clk);
    srcPulse = '0;
    check("R9 wake with master off", 32'(wakeOut), 32'h1);
    check("R9 irq stays low", 32'(irqOut), 32'h0);
    @(negedge clk);
    check("R9 wake is one cycle", 32'(wakeOut), 32'h0);
    pulse(32'h0000_0200);
    check("R9 disabled source no wake", 32'(wakeOut), 32'h0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_halves();
    t_raise();
    t_clear();
    t_race();
    t_unmapped();
    t_irq();
    t_wake();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule